// File: doc/BRIEF.md
# Randomized Periodic Operation Sampler

The block picks one operation out of a programmable interval and freezes a snapshot of it for a handler to read. Software writes a control word that carries a 16-bit interval field in units of 16 events, an enable bit, a valid bit and a count-source select. While armed, a 20-bit current count advances on every clock or only on cycles where the operation strobe is high. When the count reaches sixteen times the interval field, the block captures the sample data input, sets valid, clears enable and pulses an interrupt. It then stays frozen until software arms it again.

A built-in 16-bit LFSR takes one step on each write that sets the enable bit, so that intervals do not line up with program loops. There are two build-time variants. In the preloading variant, the low 12 bits of the current count start from the LFSR. The interval field is raised by 128 to make up for the average head start, and saturates at its maximum value. In the jitter variant, the current count starts at zero. The interval field is first clamped to a safe range and then shifted by a signed 8-bit offset taken from the LFSR.

The control word and the capture register are both read through one read port.

Top module: `rand_sampler`

## Requirements
- R1: After reset the control word and the capture register read as zero, the interrupt is low, and the LFSR holds 0xF00D.
- R2: Each control write with enable (bit 17) set steps the LFSR once. The new state is {s[0]^s[2]^s[3]^s[5], s[15:1]}, and that new state feeds the arming values. No other event changes the LFSR.
- R3: In the preloading variant, an arming write with interval field M (bits [15:0]) stores min(M+128, 0xFFFF) as the interval. It also loads the current count with the new LFSR bits [11:0], zero-extended to 20 bits.
- R4: In the jitter variant, an arming write stores clamp(M, 0x0081, 0xFF80) plus the new LFSR bits [11:4] read as a signed 8-bit value. The current count is loaded with zero.
- R5: The block is armed while enable is 1 and valid (bit 18) is 0. When bit 19 is 1, an armed block adds one to the current count on each cycle where the operation strobe is high. When bit 19 is 0, it adds one on every cycle.
- R6: When an increment brings the current count to sixteen times the interval or beyond, that same edge does four things: it captures the sample data input, sets valid, clears enable and raises the interrupt. The interrupt is high for exactly the following cycle.
- R7: While valid is set, strobes and sample data have no effect. The current count, the capture register and the control word stay unchanged, and no interrupt is raised.
- R8: A write with enable clear stores the interval, valid and select fields as written and sets the current count to zero. It does not step the LFSR. An all-zero write leaves the block idle.
- R9: With the read select at 0, the read port returns the control word: interval in [15:0], enable in 17, valid in 18, select in 19, current count in [51:32], and zeros elsewhere. With the read select at 1, it returns the capture register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 64 | Control write data |
| rd_sel | input | 1 | Read select: 0 control word, 1 capture |
| rd_data | output | 64 | Read data |
| op_strobe | input | 1 | One operation retired this cycle |
| samp_data | input | DATA_W (64) | Tagged-operation data to capture |
| irq | output | 1 | One-cycle sample interrupt |

## Verification
The bench recomputes the LFSR sequence and both arming formulas on its own, and times each interval to the exact cycle in both count modes. A design with an off-by-one terminal compare, or with the LFSR stepped in the wrong place, would fire one cycle off or read back the wrong start value. Directed writes check the corners: saturation at 0xFFFF, the low and high clamp bounds of the jitter variant, and a start count at or above the period, which must fire on the first event. Strobes sent after a capture expose a block that keeps counting or overwrites its snapshot. A disarming write that carries nonzero count bits exposes a block that loads those bits or steps the LFSR anyway.

// File: rtl/rand_sampler_pkg.sv
package rand_sampler_pkg;

    localparam int LFSR_W  = 16;
    localparam int EN_BIT  = 17;
    localparam int VAL_BIT = 18;
    localparam int SEL_BIT = 19;
    localparam int CUR_LSB = 32;
    localparam int REG_W   = 64;

    // One step of the sampler LFSR: taps 0,2,3,5, shift right, feedback in MSB.
    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[0] ^ s[2] ^ s[3] ^ s[5], s[LFSR_W-1:1]};
    endfunction

endpackage

// File: rtl/rs_lfsr.sv
module rs_lfsr
    import rand_sampler_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'hF00D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    output logic [LFSR_W-1:0] next_o,
    output logic [LFSR_W-1:0] state_o
);

    logic [LFSR_W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        next_o = lfsr_next(lfsr_q);
        lfsr_d = adv_i ? next_o : lfsr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign state_o = lfsr_q;

endmodule

// File: rtl/rs_arm_calc.sv
module rs_arm_calc
    import rand_sampler_pkg::*;
#(
    parameter int MAX_W        = 16,
    parameter int CNT_W        = 20,
    parameter int RAND_W       = 12,
    parameter bit CUR_WRITABLE = 1'b1
) (
    input  logic [MAX_W-1:0]  req_max_i,
    input  logic [LFSR_W-1:0] rnd_i,
    output logic [MAX_W-1:0]  arm_max_o,
    output logic [CNT_W-1:0]  arm_cur_o
);

    localparam int JIT_W   = 8;
    localparam int JIT_LSB = RAND_W - JIT_W;
    localparam logic [MAX_W:0]   HEAD_OFS = (MAX_W+1)'(1) << (RAND_W - 5);
    localparam logic [MAX_W-1:0] CLAMP_LO = MAX_W'((1 << (JIT_W - 1)) + 1);
    localparam logic [MAX_W-1:0] CLAMP_HI = MAX_W'((1 << MAX_W) - (1 << (JIT_W - 1)));

    generate
        if (CUR_WRITABLE) begin : g_preload
            logic [MAX_W:0] raised;
            always_comb begin
                raised    = {1'b0, req_max_i} + HEAD_OFS;
                arm_max_o = raised[MAX_W] ? {MAX_W{1'b1}} : raised[MAX_W-1:0];
                arm_cur_o = CNT_W'(rnd_i[RAND_W-1:0]);
            end
        end else begin : g_jitter
            logic [MAX_W-1:0] clamped;
            logic [JIT_W-1:0] jit;
            always_comb begin
                if (req_max_i < CLAMP_LO)      clamped = CLAMP_LO;
                else if (req_max_i > CLAMP_HI) clamped = CLAMP_HI;
                else                           clamped = req_max_i;
                jit       = rnd_i[JIT_LSB +: JIT_W];
                arm_max_o = clamped + {{(MAX_W-JIT_W){jit[JIT_W-1]}}, jit};
                arm_cur_o = '0;
            end
        end
    endgenerate

endmodule

// File: rtl/rand_sampler.sv
module rand_sampler
    import rand_sampler_pkg::*;
#(
    parameter int MAX_W        = 16,
    parameter int SCALE_SH     = 4,
    parameter int RAND_W       = 12,
    parameter int DATA_W       = 64,
    parameter bit CUR_WRITABLE = 1'b1,
    parameter logic [LFSR_W-1:0] SEED = 16'hF00D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [REG_W-1:0]  ctl_wdata,
    input  logic              rd_sel,
    output logic [REG_W-1:0]  rd_data,
    input  logic              op_strobe,
    input  logic [DATA_W-1:0] samp_data,
    output logic              irq
);

    localparam int CNT_W = MAX_W + SCALE_SH;

    typedef struct packed {
        logic [MAX_W-1:0]  max;
        logic [CNT_W-1:0]  cur;
        logic              en;
        logic              valid;
        logic              sel;
        logic [DATA_W-1:0] cap;
        logic              irq;
    } samp_state_t;

    samp_state_t st_d, st_q;

    logic              lfsr_adv;
    logic [LFSR_W-1:0] lfsr_nx, lfsr_cur;
    logic [MAX_W-1:0]  arm_max;
    logic [CNT_W-1:0]  arm_cur;
    logic [CNT_W:0]    cur_inc, period_ext;
    logic [REG_W-1:0]  ctl_word;

    // Exposed for the bound checker.
    logic              mon_en, mon_valid, mon_sel;
    logic [CNT_W-1:0]  mon_cur;
    logic [DATA_W-1:0] mon_cap;

    rs_lfsr #(.SEED(SEED)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (lfsr_adv),
        .next_o  (lfsr_nx),
        .state_o (lfsr_cur)
    );

    rs_arm_calc #(
        .MAX_W        (MAX_W),
        .CNT_W        (CNT_W),
        .RAND_W       (RAND_W),
        .CUR_WRITABLE (CUR_WRITABLE)
    ) u_arm (
        .req_max_i (ctl_wdata[MAX_W-1:0]),
        .rnd_i     (lfsr_nx),
        .arm_max_o (arm_max),
        .arm_cur_o (arm_cur)
    );

    always_comb begin
        st_d       = st_q;
        st_d.irq   = 1'b0;
        lfsr_adv   = 1'b0;
        cur_inc    = {1'b0, st_q.cur} + (CNT_W+1)'(1);
        period_ext = {1'b0, st_q.max, {SCALE_SH{1'b0}}};
        if (ctl_wr) begin
            st_d.en    = ctl_wdata[EN_BIT];
            st_d.valid = ctl_wdata[VAL_BIT];
            st_d.sel   = ctl_wdata[SEL_BIT];
            if (ctl_wdata[EN_BIT]) begin
                lfsr_adv  = 1'b1;
                st_d.max  = arm_max;
                st_d.cur  = arm_cur;
            end else begin
                st_d.max  = ctl_wdata[MAX_W-1:0];
                st_d.cur  = '0;
            end
        end else if (st_q.en && !st_q.valid && (!st_q.sel || op_strobe)) begin
            st_d.cur = cur_inc[CNT_W-1:0];
            if (cur_inc >= period_ext) begin
                st_d.cap   = samp_data;
                st_d.valid = 1'b1;
                st_d.en    = 1'b0;
                st_d.irq   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ctl_word                    = '0;
        ctl_word[MAX_W-1:0]         = st_q.max;
        ctl_word[EN_BIT]            = st_q.en;
        ctl_word[VAL_BIT]           = st_q.valid;
        ctl_word[SEL_BIT]           = st_q.sel;
        ctl_word[CUR_LSB +: CNT_W]  = st_q.cur;
        rd_data = rd_sel ? REG_W'(st_q.cap) : ctl_word;
    end

    assign irq       = st_q.irq;
    assign mon_en    = st_q.en;
    assign mon_valid = st_q.valid;
    assign mon_sel   = st_q.sel;
    assign mon_cur   = st_q.cur;
    assign mon_cap   = st_q.cap;

endmodule

// File: rtl/rand_sampler_chk.sv
module rand_sampler_chk
    import rand_sampler_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_wr,
    input logic              wr_arm,
    input logic              op_strobe,
    input logic              irq,
    input logic              en,
    input logic              valid,
    input logic              sel,
    input logic [CNT_W-1:0]  cur,
    input logic [DATA_W-1:0] cap,
    input logic [LFSR_W-1:0] lfsr
);

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R6
    AST_IRQ_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (valid && !en)); // R6
    AST_CAP_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap) |-> irq); // R6
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ctl_wr) |=> ($stable(cur) && $stable(cap) && !irq)); // R7
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !valid && !ctl_wr && (!sel || op_strobe)) |=> (cur == $past(cur) + CNT_W'(1))); // R5
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sel && !op_strobe && !ctl_wr) |=> $stable(cur)); // R5
    AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !ctl_wr) |=> ($stable(cur) && !irq)); // R8
    AST_LFSR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wr_arm) |=> (lfsr == lfsr_next($past(lfsr)))); // R2
    AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_wr && wr_arm) |=> $stable(lfsr)); // R2

endmodule

bind rand_sampler rand_sampler_chk #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .wr_arm    (ctl_wdata[rand_sampler_pkg::EN_BIT]),
    .op_strobe (op_strobe),
    .irq       (irq),
    .en        (mon_en),
    .valid     (mon_valid),
    .sel       (mon_sel),
    .cur       (mon_cur),
    .cap       (mon_cap),
    .lfsr      (lfsr_cur)
);

// File: tb/test_rand_sampler.sv
module test_rand_sampler;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n;
    logic        ctl_wr    [2];
    logic [63:0] ctl_wdata [2];
    logic        rd_sel    [2];
    logic [63:0] rd_data   [2];
    logic        op_strobe [2];
    logic [63:0] samp_data [2];
    logic        irq       [2];

    rand_sampler #(.CUR_WRITABLE(1'b1)) i_rand_sampler (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr[0]), .ctl_wdata(ctl_wdata[0]),
        .rd_sel(rd_sel[0]), .rd_data(rd_data[0]), .op_strobe(op_strobe[0]),
        .samp_data(samp_data[0]), .irq(irq[0]));

    rand_sampler #(.CUR_WRITABLE(1'b0)) i_rand_sampler_fb (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr[1]), .ctl_wdata(ctl_wdata[1]),
        .rd_sel(rd_sel[1]), .rd_data(rd_data[1]), .op_strobe(op_strobe[1]),
        .samp_data(samp_data[1]), .irq(irq[1]));

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    logic [15:0] lf_m [2];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] f_step(input logic [15:0] s);
        return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
    endfunction

    function automatic logic [15:0] f_max(input int u, input logic [15:0] m, input logic [15:0] r);
        logic [16:0] s;
        logic [15:0] c;
        if (u == 0) begin
            s = {1'b0, m} + 17'd128;
            return s[16] ? 16'hFFFF : s[15:0];
        end
        c = (m < 16'h0081) ? 16'h0081 : (m > 16'hFF80) ? 16'hFF80 : m;
        return c + {{8{r[11]}}, r[11:4]};
    endfunction

    function automatic logic [19:0] f_cur(input int u, input logic [15:0] r);
        return (u == 0) ? {8'h00, r[11:0]} : 20'h0;
    endfunction

    function automatic logic [63:0] f_ctrl(input logic [19:0] cur, input bit sel, input bit val,
                                           input bit en, input logic [15:0] mx);
        logic [63:0] w;
        w = '0; w[15:0] = mx; w[17] = en; w[18] = val; w[19] = sel; w[51:32] = cur;
        return w;
    endfunction

    task automatic rd(input int u, input bit s, output logic [63:0] v);
        rd_sel[u] = s;
        #0.5;
        v = rd_data[u];
    endtask

    task automatic wr(input int u, input logic [63:0] d);
        @(negedge clk);
        ctl_wr[u] = 1'b1; ctl_wdata[u] = d; op_strobe[u] = 1'b0;
        @(negedge clk);
        ctl_wr[u] = 1'b0; ctl_wdata[u] = '0;
    endtask

    task automatic arm(input int u, input logic [15:0] m, input bit sel,
                       output logic [15:0] mx, output logic [19:0] cur);
        logic [63:0] w, v;
        lf_m[u] = f_step(lf_m[u]);
        mx  = f_max(u, m, lf_m[u]);
        cur = f_cur(u, lf_m[u]);
        w = '0; w[15:0] = m; w[17] = 1'b1; w[19] = sel;
        wr(u, w);
        rd(u, 1'b0, v);
        check((u == 0) ? "R3 R2 arm readback" : "R4 R2 arm readback", v, f_ctrl(cur, sel, 1'b0, 1'b1, mx));
    endtask

    task automatic run(input int u, input bit sel, input logic [15:0] m);
        logic [15:0] mx;
        logic [19:0] cur;
        logic [20:0] per;
        logic [63:0] v, r, exp_cap, cap0;
        int need, cnt, it;
        bit s, hit, anyirq;
        arm(u, m, sel, mx, cur);
        per  = {1'b0, mx, 4'b0};
        need = (per > {1'b0, cur}) ? int'(per - {1'b0, cur}) : 1;
        cnt = 0; hit = 0; exp_cap = '0;
        for (it = 0; it < 20000; it++) begin
            s = sel ? 1'($urandom % 2) : 1'b1;
            r = {$urandom, $urandom};
            op_strobe[u] = s; samp_data[u] = r;
            if (!sel || s) begin
                cnt++;
                if (cnt == need) exp_cap = r;
            end
            @(negedge clk);
            if (irq[u]) begin hit = 1; break; end
        end
        op_strobe[u] = 1'b0;
        check("R6 R5 interrupt raised", 64'(hit), 64'd1);
        check("R5 R6 events to interrupt", 64'(cnt), 64'(need));
        rd(u, 1'b1, v);
        check("R6 R9 captured data", v, exp_cap);
        rd(u, 1'b0, v);
        check("R6 R9 control after sample", v, f_ctrl(cur + 20'(need), sel, 1'b1, 1'b0, mx));
        @(negedge clk);
        check("R6 interrupt one cycle", 64'(irq[u]), 64'd0);
        // R7: strobes after capture are ignored
        rd(u, 1'b1, cap0);
        anyirq = 0;
        for (int k = 0; k < 20; k++) begin
            op_strobe[u] = 1'b1; samp_data[u] = {$urandom, $urandom};
            @(negedge clk);
            if (irq[u]) anyirq = 1;
        end
        op_strobe[u] = 1'b0;
        check("R7 no interrupt while valid", 64'(anyirq), 64'd0);
        rd(u, 1'b1, v);
        check("R7 capture held", v, cap0);
        rd(u, 1'b0, v);
        check("R7 control held", v, f_ctrl(cur + 20'(need), sel, 1'b1, 1'b0, mx));
    endtask

    initial begin
        logic [63:0] v, w;
        logic [15:0] mx;
        logic [19:0] cur;
        bit anyirq;
        void'($urandom(32'h5A17));
        rst_n = 1'b0;
        for (int u = 0; u < 2; u++) begin
            ctl_wr[u] = 0; ctl_wdata[u] = '0; rd_sel[u] = 0;
            op_strobe[u] = 0; samp_data[u] = '0; lf_m[u] = 16'hF00D;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int u = 0; u < 2; u++) begin
            rd(u, 1'b0, v); check("R1 reset control", v, 64'h0);
            rd(u, 1'b1, v); check("R1 reset capture", v, 64'h0);
            check("R1 reset irq", 64'(irq[u]), 64'd0);
        end

        // preloading variant
        run(0, 1'b0, 16'h0010 + 16'($urandom % 32));
        run(0, 1'b1, 16'h0010 + 16'($urandom % 32));
        // R8: disarmed write keeps fields, zeroes count, no LFSR step
        w = '0; w[15:0] = 16'h1234; w[19] = 1'b1; w[51:32] = 20'hABCDE;
        wr(0, w);
        rd(0, 1'b0, v);
        check("R8 disarmed write fields", v, f_ctrl(20'h0, 1'b1, 1'b0, 1'b0, 16'h1234));
        anyirq = 0;
        for (int k = 0; k < 30; k++) begin
            op_strobe[0] = 1'b1; @(negedge clk); if (irq[0]) anyirq = 1;
        end
        op_strobe[0] = 1'b0;
        check("R8 no counting when disabled", 64'(anyirq), 64'd0);
        rd(0, 1'b0, v);
        check("R8 count stays zero", v, f_ctrl(20'h0, 1'b1, 1'b0, 1'b0, 16'h1234));
        wr(0, 64'h0);
        rd(0, 1'b0, v);
        check("R8 all-zero write", v, 64'h0);
        // R3 saturation corners
        arm(0, 16'hFFC0, 1'b1, mx, cur);
        check("R3 saturate", 64'(mx), 64'hFFFF);
        arm(0, 16'hFF70, 1'b1, mx, cur);
        check("R3 no saturate", 64'(mx), 64'hFFF0);
        wr(0, 64'h0);
        run(0, 1'b1, 16'h0000);

        // jitter variant
        run(1, 1'b0, 16'($urandom % 96));
        arm(1, 16'h0000, 1'b1, mx, cur);
        check("R4 low clamp range", 64'(mx >= 16'h0001 && mx <= 16'h0100), 64'd1);
        arm(1, 16'hFFFF, 1'b1, mx, cur);
        check("R4 high clamp range", 64'(mx >= 16'hFF00), 64'd1);
        wr(1, 64'h0);
        run(1, 1'b1, 16'h0040);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule